// File: doc/BRIEF.md
# Digital Preregulator PWM Controller

This block drives the gate of a DC-DC preregulator that supplies the rail of a linear output stage. A free-running period counter produces a single PWM output, about 200 kHz when the period is set for the system clock. Each new ADC sample of the rail, the output voltage and the load current runs one step of a discrete PID loop. The loop does not regulate the headroom voltage. It regulates the power burned in the linear stage, (rail − output) × load current, so the headroom grows by itself when the load is light.

On enable, the duty is capped by a soft-start ramp that rises from zero, which limits inrush from the supply input. A step request forces a full-load duty for a programmed number of clocks before the PID takes over again. A saturation guard pushes the duty to its maximum while the rail is too close to the output. Two sets of gains and power setpoints are held, one for the main supply input and one for an auxiliary source, and a select input picks between them.

Top module: `prereg_pwm_ctrl`

## Requirements
- R1: The PWM counter runs from 0 to `pwmPeriod`−1 while enabled. `pwmOut` is high while the count is below the applied duty. A new duty is applied only when the counter wraps, so every period carries one constant duty.
- R2: The soft-start limit is 0 at enable. At the n-th wrap it becomes min(n·`rampStep`, `dutyMax`), and the duty applied at that wrap is at most this limit, so period n has at most that duty. `softStartDone` is high while enabled once the limit has reached `dutyMax`.
- R3: On each sample the loop computes power = (rail − vout)·iload and err = powerSet − power. It then computes acc = integ + kp·err + kd·(err − prevErr), and the PID duty is acc arithmetically shifted right by 4. A gain of 16 therefore means 1.0. All values are signed.
- R4: The integrator is updated as integ + ki·err, and the result is clamped to ±`intLimit`.
- R5: The PID duty is clamped to [`dutyMin`, `dutyMax`]. The applied duty never exceeds `dutyMax`.
- R6: A `stepReq` pulse loads a window of `stepCycles` clocks. During the window the selected duty is `fullLoadDuty`, and samples taken in the window leave the PID state unchanged.
- R7: `srcAux`=1 selects the auxiliary gains and power setpoint, and `srcAux`=0 selects the main set.
- R8: PID state changes only in a cycle with `sampleValid` high. Changes to the sample inputs without the strobe have no effect on the duty.
- R9: With `enable` low, `pwmOut`, `softStartDone` and `saturated` are low in the same cycle. The counter, the ramp, the integrator, the previous error and the step window are cleared at the next clock.
- R10: On each sample, if rail < max(vout, `setpoint`) + `minHeadroom`, then `saturated` is set and the selected duty is `dutyMax`. Saturation takes priority over the step window, and the step window over the PID. A sample that passes the test clears the flag.
- R11: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the converter; low forces the drive off and clears state |
| srcAux | input | 1 | 1 selects the auxiliary-source gain set |
| stepReq | input | 1 | Pulse on a new output setpoint request |
| sampleValid | input | 1 | New ADC sample strobe |
| railSample | input | ADC_W | Rail voltage sample |
| voutSample | input | ADC_W | Output voltage sample |
| iloadSample | input | ADC_W | Load current sample |
| setpoint | input | ADC_W | Programmed output voltage |
| pwmPeriod | input | DUTY_W | PWM period in clocks |
| rampStep | input | DUTY_W | Soft-start increment per period |
| dutyMin | input | DUTY_W | Lowest PID duty |
| dutyMax | input | DUTY_W | Highest duty |
| fullLoadDuty | input | DUTY_W | Duty forced after a step request |
| stepCycles | input | STEP_W | Length of the forced window in clocks |
| minHeadroom | input | ADC_W | Smallest allowed rail-to-output margin |
| intLimit | input | ACC_W-1 | Integrator magnitude limit |
| kpMain | input | COEF_W | Proportional gain, main set (signed) |
| kiMain | input | COEF_W | Integral gain, main set (signed) |
| kdMain | input | COEF_W | Derivative gain, main set (signed) |
| powerSetMain | input | 2*ADC_W | Linear-stage power target, main set |
| kpAux | input | COEF_W | Proportional gain, auxiliary set (signed) |
| kiAux | input | COEF_W | Integral gain, auxiliary set (signed) |
| kdAux | input | COEF_W | Derivative gain, auxiliary set (signed) |
| powerSetAux | input | 2*ADC_W | Linear-stage power target, auxiliary set |
| pwmOut | output | 1 | Gate drive |
| softStartDone | output | 1 | Ramp limit has reached dutyMax |
| saturated | output | 1 | Rail headroom below the minimum |

## Verification
A wrong integrator, previous-error or PID duty register shows up as a wrong high-time per period on `pwmOut`. It becomes visible from the first counter wrap after the sample that exposes it, so at most one PWM period plus one clock later. A wrong ramp or window counter changes the per-period duty sequence after enable or after a step request, and it shifts the cycle in which `softStartDone` rises. A stale saturation state is visible on `saturated` one clock after the next sample.

// File: rtl/prereg_pkg.sv
package prereg_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic sampleSeen;  // sample arrived while enabled
    logic sampleUpd;   // sample may update PID state
    logic forceFull;   // step window active
    logic wrap;        // last count of the PWM period
    logic clear;       // converter disabled
  } ctrlStrobe_t;
endpackage

// File: rtl/prereg_ctrl.sv
module prereg_ctrl
  import prereg_pkg::*;
#(
  parameter int DUTY_W = 10,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              stepReq,
  input  logic              sampleValid,
  input  logic [DUTY_W-1:0] pwmPeriod,
  input  logic [STEP_W-1:0] stepCycles,
  output logic [DUTY_W-1:0] cnt,
  output ctrlStrobe_t       strb
);
  logic [STEP_W-1:0] winCnt;
  logic              lastCount;

  assign lastCount = ({1'b0, cnt} + 1'b1) >= {1'b0, pwmPeriod};

  always_comb begin
    strb.clear      = !enable;
    strb.wrap       = enable && lastCount;
    strb.forceFull  = winCnt != '0;
    strb.sampleSeen = enable && sampleValid;
    strb.sampleUpd  = enable && sampleValid && (winCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      winCnt <= '0;
    end else if (!enable) begin
      cnt    <= '0;
      winCnt <= '0;
    end else begin
      cnt <= lastCount ? '0 : cnt + 1'b1;
      if (stepReq)
        winCnt <= stepCycles;
      else if (winCnt != '0)
        winCnt <= winCnt - 1'b1;
    end
  end
endmodule

// File: rtl/prereg_dp.sv
module prereg_dp
  import prereg_pkg::*;
#(
  parameter int ADC_W  = 12,
  parameter int DUTY_W = 10,
  parameter int COEF_W = 8,
  parameter int FRAC   = 4,
  localparam int PW_W  = 2 * ADC_W,
  localparam int ACC_W = 2 * ADC_W + COEF_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [DUTY_W-1:0] cnt,
  input  logic              srcAux,
  input  logic [ADC_W-1:0]  railSample,
  input  logic [ADC_W-1:0]  voutSample,
  input  logic [ADC_W-1:0]  iloadSample,
  input  logic [ADC_W-1:0]  setpoint,
  input  logic [ADC_W-1:0]  minHeadroom,
  input  logic [DUTY_W-1:0] rampStep,
  input  logic [DUTY_W-1:0] dutyMin,
  input  logic [DUTY_W-1:0] dutyMax,
  input  logic [DUTY_W-1:0] fullLoadDuty,
  input  logic [ACC_W-2:0]  intLimit,
  input  logic [COEF_W-1:0] kpMain,
  input  logic [COEF_W-1:0] kiMain,
  input  logic [COEF_W-1:0] kdMain,
  input  logic [PW_W-1:0]   powerSetMain,
  input  logic [COEF_W-1:0] kpAux,
  input  logic [COEF_W-1:0] kiAux,
  input  logic [COEF_W-1:0] kdAux,
  input  logic [PW_W-1:0]   powerSetAux,
  output logic [DUTY_W-1:0] dutyApplied,
  output logic              pwmOut,
  output logic              softStartDone,
  output logic              saturated
);
  logic signed [ACC_W-1:0] integ, prevErr;
  logic [DUTY_W-1:0]       pidDuty, rampLimit;
  logic                    satReg;

  // gain set selection
  logic signed [ACC_W-1:0] kpS, kiS, kdS, pSetS;
  always_comb begin
    kpS   = ACC_W'($signed(srcAux ? kpAux : kpMain));
    kiS   = ACC_W'($signed(srcAux ? kiAux : kiMain));
    kdS   = ACC_W'($signed(srcAux ? kdAux : kdMain));
    pSetS = $signed(ACC_W'(srcAux ? powerSetAux : powerSetMain));
  end

  // linear-stage power and PID step
  logic signed [ACC_W-1:0] headroom, power, err, integSum, integNext;
  logic signed [ACC_W-1:0] limS, acc, shifted, minS, maxS;
  logic [DUTY_W-1:0]       pidNext;
  always_comb begin
    headroom = $signed(ACC_W'(railSample)) - $signed(ACC_W'(voutSample));
    power    = headroom * $signed(ACC_W'(iloadSample));
    err      = pSetS - power;
    limS     = $signed({1'b0, intLimit});
    integSum = integ + kiS * err;
    if (integSum > limS)       integNext = limS;
    else if (integSum < -limS) integNext = -limS;
    else                       integNext = integSum;
    acc     = integNext + kpS * err + kdS * (err - prevErr);
    shifted = acc >>> FRAC;
    minS    = $signed(ACC_W'(dutyMin));
    maxS    = $signed(ACC_W'(dutyMax));
    if (shifted < minS)      pidNext = dutyMin;
    else if (shifted > maxS) pidNext = dutyMax;
    else                     pidNext = shifted[DUTY_W-1:0];
  end

  // headroom guard
  logic [ADC_W-1:0] satRef;
  logic             satNow;
  always_comb begin
    satRef = (voutSample > setpoint) ? voutSample : setpoint;
    satNow = {1'b0, railSample} < ({1'b0, satRef} + {1'b0, minHeadroom});
  end

  // soft-start ramp and duty selection
  logic [DUTY_W:0]   rampSum;
  logic [DUTY_W-1:0] rampNext, dutySel, dutyCmd;
  always_comb begin
    rampSum  = {1'b0, rampLimit} + {1'b0, rampStep};
    rampNext = (rampSum > {1'b0, dutyMax}) ? dutyMax : rampSum[DUTY_W-1:0];
    if (satReg)              dutySel = dutyMax;
    else if (strb.forceFull) dutySel = fullLoadDuty;
    else                     dutySel = pidDuty;
    dutyCmd = (dutySel < rampNext) ? dutySel : rampNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      integ <= '0; prevErr <= '0; pidDuty <= '0;
      rampLimit <= '0; dutyApplied <= '0; satReg <= 1'b0;
    end else if (strb.clear) begin
      integ <= '0; prevErr <= '0; pidDuty <= '0;
      rampLimit <= '0; dutyApplied <= '0; satReg <= 1'b0;
    end else begin
      if (strb.sampleUpd) begin
        integ   <= integNext;
        prevErr <= err;
        pidDuty <= pidNext;
      end
      if (strb.sampleSeen) satReg <= satNow;
      if (strb.wrap) begin
        rampLimit   <= rampNext;
        dutyApplied <= dutyCmd;
      end
    end
  end

  assign pwmOut        = !strb.clear && (cnt < dutyApplied);
  assign softStartDone = !strb.clear && (rampLimit >= dutyMax);
  assign saturated     = !strb.clear && satReg;
endmodule

// File: rtl/prereg_pwm_ctrl.sv
module prereg_pwm_ctrl
  import prereg_pkg::*;
#(
  parameter int ADC_W  = 12,
  parameter int DUTY_W = 10,
  parameter int COEF_W = 8,
  parameter int STEP_W = 16,
  parameter int FRAC   = 4,
  localparam int PW_W  = 2 * ADC_W,
  localparam int ACC_W = 2 * ADC_W + COEF_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              srcAux,
  input  logic              stepReq,
  input  logic              sampleValid,
  input  logic [ADC_W-1:0]  railSample,
  input  logic [ADC_W-1:0]  voutSample,
  input  logic [ADC_W-1:0]  iloadSample,
  input  logic [ADC_W-1:0]  setpoint,
  input  logic [DUTY_W-1:0] pwmPeriod,
  input  logic [DUTY_W-1:0] rampStep,
  input  logic [DUTY_W-1:0] dutyMin,
  input  logic [DUTY_W-1:0] dutyMax,
  input  logic [DUTY_W-1:0] fullLoadDuty,
  input  logic [STEP_W-1:0] stepCycles,
  input  logic [ADC_W-1:0]  minHeadroom,
  input  logic [ACC_W-2:0]  intLimit,
  input  logic [COEF_W-1:0] kpMain,
  input  logic [COEF_W-1:0] kiMain,
  input  logic [COEF_W-1:0] kdMain,
  input  logic [PW_W-1:0]   powerSetMain,
  input  logic [COEF_W-1:0] kpAux,
  input  logic [COEF_W-1:0] kiAux,
  input  logic [COEF_W-1:0] kdAux,
  input  logic [PW_W-1:0]   powerSetAux,
  output logic              pwmOut,
  output logic              softStartDone,
  output logic              saturated
);
  ctrlStrobe_t       strb;
  logic [DUTY_W-1:0] cnt;
  logic [DUTY_W-1:0] dutyApplied;

  prereg_ctrl #(.DUTY_W(DUTY_W), .STEP_W(STEP_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .stepReq(stepReq),
    .sampleValid(sampleValid), .pwmPeriod(pwmPeriod),
    .stepCycles(stepCycles), .cnt(cnt), .strb(strb)
  );

  prereg_dp #(.ADC_W(ADC_W), .DUTY_W(DUTY_W), .COEF_W(COEF_W), .FRAC(FRAC)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cnt(cnt), .srcAux(srcAux),
    .railSample(railSample), .voutSample(voutSample),
    .iloadSample(iloadSample), .setpoint(setpoint),
    .minHeadroom(minHeadroom), .rampStep(rampStep), .dutyMin(dutyMin),
    .dutyMax(dutyMax), .fullLoadDuty(fullLoadDuty), .intLimit(intLimit),
    .kpMain(kpMain), .kiMain(kiMain), .kdMain(kdMain),
    .powerSetMain(powerSetMain), .kpAux(kpAux), .kiAux(kiAux),
    .kdAux(kdAux), .powerSetAux(powerSetAux), .dutyApplied(dutyApplied),
    .pwmOut(pwmOut), .softStartDone(softStartDone), .saturated(saturated)
  );
endmodule

// File: rtl/prereg_checker.sv
module prereg_checker #(
  parameter int DUTY_W = 10,
  parameter int STEP_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              stepReq,
  input logic [STEP_W-1:0] stepCycles,
  input logic [DUTY_W-1:0] pwmPeriod,
  input logic [DUTY_W-1:0] dutyMax,
  input logic [DUTY_W-1:0] cnt,
  input logic [DUTY_W-1:0] dutyApplied,
  input logic              forceFull,
  input logic              pwmOut,
  input logic              softStartDone
);
  p_period_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    enable && pwmPeriod != '0 |-> cnt < pwmPeriod);

  p_duty_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    enable && $past(enable) && cnt != '0 |-> $stable(dutyApplied));

  p_done_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    enable && softStartDone |=> softStartDone || !enable);

  p_duty_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> dutyApplied <= dutyMax);

  p_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    enable && stepReq && stepCycles != '0 |=> forceFull || !enable);

  p_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pwmOut);
endmodule

bind prereg_pwm_ctrl prereg_checker #(.DUTY_W(DUTY_W), .STEP_W(STEP_W)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .stepReq(stepReq),
  .stepCycles(stepCycles), .pwmPeriod(pwmPeriod), .dutyMax(dutyMax),
  .cnt(cnt), .dutyApplied(dutyApplied), .forceFull(strb.forceFull),
  .pwmOut(pwmOut), .softStartDone(softStartDone)
);

// File: tb/prereg_pwm_ctrl_test.sv
module prereg_pwm_ctrl_test;
  localparam int ADC_W = 12, DUTY_W = 10, COEF_W = 8, STEP_W = 16;
  localparam int ACC_W = 2 * ADC_W + COEF_W + 4;
  localparam int P = 20;

  logic clk = 1'b0, rstN = 1'b0;
  logic enable = 0, srcAux = 0, stepReq = 0, sampleValid = 0;
  logic [ADC_W-1:0]  railSample = 100, voutSample = 90, iloadSample = 1;
  logic [ADC_W-1:0]  setpoint = 50, minHeadroom = 5;
  logic [DUTY_W-1:0] pwmPeriod = P, rampStep = 4, dutyMin = 2, dutyMax = 16;
  logic [DUTY_W-1:0] fullLoadDuty = 14;
  logic [STEP_W-1:0] stepCycles = 60;
  logic [ACC_W-2:0]  intLimit = 128;
  logic [COEF_W-1:0] kpMain = 16, kiMain = 0, kdMain = 0;
  logic [COEF_W-1:0] kpAux = 16, kiAux = 0, kdAux = 0;
  logic [2*ADC_W-1:0] powerSetMain = 20, powerSetAux = 15;
  logic pwmOut, softStartDone, saturated;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  prereg_pwm_ctrl uut (.*);

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // called at a negedge; returns at a negedge
  task automatic measure(int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      #1 hi += int'(pwmOut);
      @(negedge clk);
    end
  endtask

  task automatic sample(int rail, int vout, int il);
    railSample = rail; voutSample = vout; iloadSample = il;
    sampleValid = 1;
    @(negedge clk);
    sampleValid = 0;
  endtask

  task automatic settledDuty(string tag, int exp);
    int hi;
    repeat (2 * P) @(negedge clk);
    measure(3 * P, hi);
    check(tag, hi, 3 * exp);
  endtask

  task automatic testReset();
    #1;
    check("R11 pwmOut", int'(pwmOut), 0);
    check("R11 softStartDone", int'(softStartDone), 0);
    check("R11 saturated", int'(saturated), 0);
  endtask

  task automatic testSoftStart();
    int hi;
    int exp;
    railSample = 92; voutSample = 90; iloadSample = 1;  // headroom 2 < 5
    enable = 1; sampleValid = 1;
    for (int n = 0; n < 6; n++) begin
      hi = 0;
      for (int i = 0; i < P; i++) begin
        #1 hi += int'(pwmOut);
        if (n == 3 && i == P - 1) check("R2 done before limit", int'(softStartDone), 0);
        if (n == 4 && i == 0) check("R2 done at limit", int'(softStartDone), 1);
        @(negedge clk);
        sampleValid = 0;
      end
      exp = (4 * n < 16) ? 4 * n : 16;
      check($sformatf("R1/R2 period %0d duty", n), hi, exp);
    end
    check("R10 saturated during ramp", int'(saturated), 1);
  endtask

  task automatic testProportional();
    sample(100, 90, 1);                         // power 10, err 10
    check("R10 flag cleared", int'(saturated), 0);
    settledDuty("R3 kp=1 duty", 10);
    railSample = 100; iloadSample = 0;          // no strobe
    settledDuty("R8 no strobe no change", 10);
  endtask

  task automatic testClamp();
    sample(100, 90, 0);                         // err 20
    settledDuty("R5 clamp high", 16);
    powerSetMain = 0;
    sample(100, 90, 1);                         // err -10
    settledDuty("R5 clamp low", 2);
    powerSetMain = 20;
    sample(100, 90, 1);
    settledDuty("R3 restore", 10);
  endtask

  task automatic testSource();
    srcAux = 1;
    sample(100, 90, 1);                         // aux err 5
    settledDuty("R7 aux set", 5);
    srcAux = 0;
    sample(100, 90, 1);
    settledDuty("R7 main set", 10);
  endtask

  task automatic testStep();
    int hi;
    stepReq = 1;
    @(negedge clk);
    stepReq = 0;
    sample(100, 90, 0);                         // ignored inside window
    repeat (22) @(negedge clk);
    measure(P, hi);
    check("R6 forced full-load duty", hi, 14);
    repeat (65) @(negedge clk);
    measure(P, hi);
    check("R6 PID back, window sample ignored", hi, 10);
  endtask

  task automatic testSaturation();
    sample(92, 90, 1);
    check("R10 flag on low rail", int'(saturated), 1);
    settledDuty("R10 duty max", 16);
    setpoint = 96;
    sample(100, 90, 1);                         // 100 < 96+5
    check("R10 setpoint above vout", int'(saturated), 1);
    setpoint = 50;
    sample(100, 90, 1);
    check("R10 flag clears", int'(saturated), 0);
    settledDuty("R10 duty back to PID", 10);
  endtask

  task automatic reEnable();
    int hi;
    enable = 0;
    measure(P, hi);
    check("R9 drive off while disabled", hi, 0);
    check("R9 done low", int'(softStartDone), 0);
    check("R9 sat low", int'(saturated), 0);
    enable = 1;
    repeat (6 * P) @(negedge clk);
  endtask

  task automatic testIntegral();
    kpMain = 0; kiMain = 16;
    sample(92, 90, 1);                          // raise saturation first
    reEnable();                                 // R9: disable also clears it
    check("R9 sat cleared by disable", int'(saturated), 0);
    powerSetMain = 13;                          // err 3
    sample(100, 90, 1);
    settledDuty("R4 integ step 1", 3);
    sample(100, 90, 1);
    settledDuty("R4 integ step 2", 6);
    sample(100, 90, 1);
    settledDuty("R4 integ clamped", 8);
    sample(100, 90, 1);
    settledDuty("R4 integ holds at limit", 8);
    reEnable();
    sample(100, 90, 1);
    settledDuty("R9 integrator cleared", 3);
  endtask

  task automatic testDerivative();
    kiMain = 0; kdMain = 16; powerSetMain = 20;
    reEnable();
    sample(100, 90, 1);                         // err 10, prev 0
    settledDuty("R3 derivative kick", 10);
    sample(100, 90, 1);                         // no change -> min
    settledDuty("R3 derivative zero", 2);
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testSoftStart();
    testProportional();
    testClamp();
    testSource();
    testStep();
    testSaturation();
    testIntegral();
    testDerivative();
    finish();
  end
endmodule